// File: doc/BRIEF.md
# Bit-Serial BCD Adder/Subtractor

This block adds or subtracts two decimal numbers that arrive one bit per clock, least significant digit first. Within each digit the bits arrive in weight order 1, 2, 4, 8. A timing block supplies a one-hot bit-slot strobe and flags that mark the first and the last digit of a number cycle. The block keeps no operand storage. It works one digit at a time.

The work is split into two serial stages. During a digit's four slots, a binary operand adder forms the 4-bit binary sum and collects it. At the weight-8 slot, a tens-carry decision is made. For addition, the carry is set when the binary sum exceeded 9 or produced a binary carry. For subtraction, the carry is the binary carry, and B is bit-inverted with a starting carry of 1. That decision picks a correction constant:
- For addition, 6 when a carry occurred and 0 otherwise.
- For subtraction, 10 (minus six modulo 16) when a borrow occurred and 0 otherwise.

During the four slots of the following digit, a normalisation adder with its own carry latch adds that constant serially and drives the corrected bits out. The corrected digit is also gathered into a 4-bit parallel register for a display path. A carry flag reports the final decimal carry of the most significant digit to the control logic.

Top module: `bcd_serial_addsub`

## Requirements
- R1: `slot_w` is one-hot or zero. Bit i marks the bit of weight 2^i (bit0 = weight 1, bit3 = weight 8). The corrected result of a digit is driven on `res_ser` during the four slots of the next digit, weight 1 first.
- R2: With `sub_mode` = 0, each result digit equals (a + b + carry-in) mod 10. A digit produces a carry when a + b + carry-in > 9.
- R3: The decimal carry out of one digit is the carry-in of the next digit, including ripple through runs of nines.
- R4: With `sub_mode` = 1, each result digit equals (a − b − borrow-in) mod 10. A digit with A < B over the whole number yields the ten's complement 10^N + A − B.
- R5: At the first slot of a number cycle (`dig_first` and `slot_w[0]`), the carry-in is 0 for addition and 1 (no borrow) for subtraction, whatever the previous cycle left.
- R6: `res_digit` loads the corrected digit (weight 1 in bit 0) at the end of that digit's last output slot (`slot_w[3]`). It holds at every other cycle.
- R7: `carry_flag` loads the final carry at the end of slot 8 of the last digit. For addition the final carry is 1 on decimal overflow. For subtraction it is 1 when A ≥ B. The flag clears at the end of the first slot of the next number cycle, and holds otherwise.
- R8: A cycle with no slot strobe changes no state, and `res_ser` is 0 during it.
- R9: After synchronous reset, `res_digit` = 0, `carry_flag` = 0, and the first digit's output slots carry zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| slot_w | input | 4 | one-hot bit-slot strobe, bit i = weight 2^i |
| dig_first | input | 1 | current digit is the least significant of the number cycle |
| dig_last | input | 1 | current digit is the most significant of the number cycle |
| sub_mode | input | 1 | 1 selects A − B, 0 selects A + B |
| a_ser | input | 1 | serial bit of operand A |
| b_ser | input | 1 | serial bit of operand B |
| res_ser | output | 1 | serial corrected result bit, one digit behind |
| res_digit | output | 4 | parallel corrected digit for the display |
| carry_flag | output | 1 | final decimal carry (no-borrow for subtraction) |

## Verification
A wrong operand carry latch or a wrong tens decision corrupts a digit's correction constant. That error appears on `res_ser` during the very next digit's slots, and on `res_digit` four slots after that. A wrong carry hand-off between digits or between number cycles shows as a wrong low bit in the following digit's output. The same fault shows as a wrong `carry_flag` at the first slot of the next cycle. Because the bench compares every slot against a behavioural decimal model, a fault surfaces within one digit time.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    localparam int DW        = 4;
    localparam int TEN_LIMIT = 9;

    typedef logic [DW-1:0] digit_t;

    // Work handed from the operand stage to the normalisation stage.
    typedef struct packed {
        digit_t bin;   // raw binary digit sum
        digit_t corr;  // constant added by the normalisation adder
    } norm_job_t;

    function automatic digit_t corr_value(input logic sub, input logic dec_c);
        if (sub) return dec_c ? digit_t'(0) : digit_t'(10);
        return dec_c ? digit_t'(6) : digit_t'(0);
    endfunction
endpackage

// File: rtl/bsa_operand_stage.sv
module bsa_operand_stage
    import bsa_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  slot_w,
    input  logic           num_start,
    input  logic           sub_mode,
    input  logic           a_bit,
    input  logic           b_bit,
    output norm_job_t      job,
    output logic           dec_carry
);
    logic          c_q;
    logic [DW-2:0] acc;
    logic          cin, bx, s_bit, co;
    digit_t        sum_full;

    assign cin      = num_start ? sub_mode : c_q;
    assign bx       = b_bit ^ sub_mode;
    assign s_bit    = a_bit ^ bx ^ cin;
    assign co       = (a_bit & bx) | (a_bit & cin) | (bx & cin);
    assign sum_full = {s_bit, acc};

    always_comb begin
        if (sub_mode) dec_carry = co;
        else          dec_carry = co | (32'(sum_full) > TEN_LIMIT);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= 1'b0;
            acc <= '0;
            job <= '0;
        end else if (|slot_w) begin
            for (int i = 0; i < DW-1; i++)
                if (slot_w[i]) acc[i] <= s_bit;
            if (slot_w[DW-1]) begin
                c_q      <= dec_carry;
                job.bin  <= sum_full;
                job.corr <= corr_value(sub_mode, dec_carry);
            end else begin
                c_q <= co;
            end
        end
    end

    // R3: an addition digit whose binary sum passed nine is given the +6 fix
    a_r3_tens_corr: assert property (@(posedge clk) disable iff (rst)
        (slot_w[DW-1] && !sub_mode) |=>
            (!(32'(job.bin) > TEN_LIMIT) || job.corr == digit_t'(6)));

    // R4: a subtraction digit carries either no fix or the minus-six fix
    a_r4_sub_corr: assert property (@(posedge clk) disable iff (rst)
        (slot_w[DW-1] && sub_mode) |=>
            (job.corr == digit_t'(0) || job.corr == digit_t'(10)));
endmodule

// File: rtl/bsa_norm_stage.sv
module bsa_norm_stage
    import bsa_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic [DW-1:0]  slot_w,
    input  norm_job_t      job,
    output logic           res_bit,
    output digit_t         digit_q
);
    logic          c2_q;
    logic [DW-2:0] sh;
    logic          active, bsel, csel, cin2, co2;

    assign active  = |slot_w;
    assign bsel    = |(job.bin & slot_w);
    assign csel    = |(job.corr & slot_w);
    assign cin2    = slot_w[0] ? 1'b0 : c2_q;
    assign res_bit = active & (bsel ^ csel ^ cin2);
    assign co2     = (bsel & csel) | (bsel & cin2) | (csel & cin2);

    always_ff @(posedge clk) begin
        if (rst) begin
            c2_q    <= 1'b0;
            sh      <= '0;
            digit_q <= '0;
        end else if (active) begin
            c2_q <= co2;
            for (int i = 0; i < DW-1; i++)
                if (slot_w[i]) sh[i] <= res_bit;
            if (slot_w[DW-1]) digit_q <= {res_bit, sh};
        end
    end

    // R6: the parallel digit moves only at the weight-8 slot
    a_r6_digit_hold: assert property (@(posedge clk) disable iff (rst)
        !slot_w[DW-1] |=> $stable(digit_q));
endmodule

// File: rtl/bcd_serial_addsub.sv
module bcd_serial_addsub
    import bsa_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    slot_w,
    input  logic          dig_first,
    input  logic          dig_last,
    input  logic          sub_mode,
    input  logic          a_ser,
    input  logic          b_ser,
    output logic          res_ser,
    output logic [3:0]    res_digit,
    output logic          carry_flag
);
    norm_job_t job;
    logic      dec_carry;
    logic      num_start;

    assign num_start = dig_first & slot_w[0];

    bsa_operand_stage u_op (
        .clk       (clk),
        .rst       (rst),
        .slot_w    (slot_w),
        .num_start (num_start),
        .sub_mode  (sub_mode),
        .a_bit     (a_ser),
        .b_bit     (b_ser),
        .job       (job),
        .dec_carry (dec_carry)
    );

    bsa_norm_stage u_norm (
        .clk     (clk),
        .rst     (rst),
        .slot_w  (slot_w),
        .job     (job),
        .res_bit (res_ser),
        .digit_q (res_digit)
    );

    always_ff @(posedge clk) begin
        if (rst)                            carry_flag <= 1'b0;
        else if (num_start)                 carry_flag <= 1'b0;
        else if (dig_last && slot_w[DW-1])  carry_flag <= dec_carry;
    end

    // R1: slot strobe is one-hot or idle
    a_r1_slot_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_w));

    // R7: the flag is low after a number cycle opens
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (rst)
        num_start |=> !carry_flag);

    // R8: idle cycles leave the visible state untouched
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (slot_w == 4'b0) |=> ($stable(res_digit) && $stable(carry_flag)));

    // R8: no serial output without a slot strobe
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (slot_w == 4'b0) |-> !res_ser);
endmodule

// File: tb/tb_bcd_serial_addsub.sv
`timescale 1ns/100ps
module tb_bcd_serial_addsub;
    localparam int ND = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] slot_w = '0;
    logic       dig_first = 1'b0, dig_last = 1'b0, sub_mode = 1'b0;
    logic       a_ser = 1'b0, b_ser = 1'b0;
    logic       res_ser;
    logic [3:0] res_digit;
    logic       carry_flag;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // behavioural expectation state
    int prevd    = 0;  // result of most recent finished digit
    int prev2d   = 0;  // result currently expected on res_digit
    int flag_exp = 0;

    always #2.5 clk = ~clk;

    bcd_serial_addsub dut (
        .clk(clk), .rst(rst), .slot_w(slot_w), .dig_first(dig_first),
        .dig_last(dig_last), .sub_mode(sub_mode), .a_ser(a_ser),
        .b_ser(b_ser), .res_ser(res_ser), .res_digit(res_digit),
        .carry_flag(carry_flag)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_slot();
        @(negedge clk);
        slot_w = '0; dig_first = 0; dig_last = 0; a_ser = 0; b_ser = 0;
        #1;
        chk("R8 idle res_ser", int'(res_ser), 0);
        chk("R8 idle res_digit", int'(res_digit), prev2d);
        chk("R8 idle carry_flag", int'(carry_flag), flag_exp);
    endtask

    task automatic run_cycle(input string req, input int a, input int b,
                             input bit s, input int gap);
        int rd[ND];
        int carry, p, ad, bd, t;
        for (int g = 0; g < gap; g++) idle_slot();
        carry = s ? 1 : 0;
        p = 1;
        for (int k = 0; k < ND; k++) begin
            ad = (a / p) % 10;
            bd = (b / p) % 10;
            if (!s) begin
                t = ad + bd + carry;
                if (t > 9) begin t -= 10; carry = 1; end else carry = 0;
            end else begin
                t = ad - bd - (carry ? 0 : 1);
                if (t < 0) begin t += 10; carry = 0; end else carry = 1;
            end
            rd[k] = t;
            p *= 10;
        end
        p = 1;
        for (int k = 0; k < ND; k++) begin
            ad = (a / p) % 10;
            bd = (b / p) % 10;
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                slot_w = 4'(1 << i);
                dig_first = (k == 0);
                dig_last  = (k == ND-1);
                sub_mode  = s;
                a_ser = ad[i];
                b_ser = bd[i];
                #1;
                chk({req, " R1 res_ser"}, int'(res_ser), (prevd >> i) & 1);
                chk("R6 res_digit", int'(res_digit), prev2d);
                chk("R7 carry_flag", int'(carry_flag), flag_exp);
                if (k == 0 && i == 0) flag_exp = 0;
            end
            prev2d = prevd;
            prevd  = rd[k];
            p *= 10;
        end
        flag_exp = carry;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R9 reset res_digit", int'(res_digit), 0);
        chk("R9 reset carry_flag", int'(carry_flag), 0);
        chk("R9 reset res_ser", int'(res_ser), 0);
        @(negedge clk);
        rst = 1'b0;
        run_cycle("R9", 0, 0, 0, 1);
        run_cycle("R2", 1234, 5678, 0, 0);
        run_cycle("R3", 5555, 4445, 0, 0);
        run_cycle("R3", 9999, 1, 0, 2);
        run_cycle("R5", 5000, 1234, 1, 0);   // subtract after overflow add
        run_cycle("R5", 0, 0, 0, 0);         // add after no-borrow subtract
        run_cycle("R4", 1234, 5000, 1, 0);
        run_cycle("R4", 7777, 7777, 1, 1);
        run_cycle("R4", 1000, 1, 1, 0);
        run_cycle("R2", 987, 13, 0, 0);
        run_cycle("R8", 4321, 1, 0, 3);
        run_cycle("R2", 0, 0, 0, 0);         // flush previous MSD
        idle_slot();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule